// File: doc/BRIEF.md
# Framer event interrupt status register

This block turns a handful of live framer and transmit-side status levels into sticky event bits, held in a status byte that software reads. Each event bit has its own detection rule. Some bits fire on a rising edge of their level, some on a falling edge, and one also fires on any change. A bit stays set until the status register is read. The read strobe clears every bit on the same clock edge, unless a new event for that bit arrives in that cycle.

A per-bit mask controls which latched events count toward the interrupt. A visibility-mode control decides what happens to masked events. With the control off, masked events are dropped entirely. With it on, masked events are still recorded in the status byte, but they never pull the interrupt pin low and never show in the global summary bit. The active-low interrupt pin comes from a register. The summary bit is a combinational view of the latched, unmasked bits.

Top module: `evt_irq_status`

## Requirements
- R1: A cycle with `rd_stb` high clears every status bit at that clock edge, except bits that receive a qualifying event in the same cycle.
- R2: Status bit 0 (line change) is set by a rising edge of `line_open` or by any transition, in either direction, of `line_short`. A falling edge of `line_open` sets nothing.
- R3: Status bit 1 (pool ready) is set by a rising edge of `pool_space`.
- R4: Status bit 2 (alignment regained) is set by a falling edge of `frame_loss`.
- R5: Status bit 3 (alignment lost) is set by a rising edge of `frame_loss`.
- R6: Status bit 4 (multiframe alignment regained) is set by a falling edge of `mframe_loss`. A rising edge of `mframe_loss` sets nothing.
- R7: With `vis_mode` high, an event on a masked bit (`irq_mask` bit = 1) is latched in `status`. Such a bit never makes `summary` high and never drives `irq_n` low.
- R8: With `vis_mode` low, an event on a masked bit is not latched, and the bit stays 0.
- R9: An event that coincides with a read leaves its bit set after the read.
- R10: `summary` is 1 exactly when some status bit is set whose mask bit is 0. `irq_n` is a register output that goes low one clock after such a bit becomes set (or at once, when the update lands on the same edge as the status update) and returns high after the bit is cleared.
- R11: A synchronous reset (`rst` high at a clock edge) clears all status bits and the stored previous levels, leaving `summary` at 0 and `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_open | input | 1 | Transmit line open level |
| line_short | input | 1 | Transmit line short level |
| frame_loss | input | 1 | Frame alignment lost level |
| mframe_loss | input | 1 | Multiframe alignment lost level |
| pool_space | input | 1 | Transmit FIFO can take a 32-byte block |
| irq_mask | input | 5 | Per-bit mask, 1 = masked |
| vis_mode | input | 1 | 1 = masked events are still latched |
| rd_stb | input | 1 | Status register read strobe |
| status | output | 5 | Latched event bits |
| summary | output | 1 | Global summary: any unmasked bit set |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
On every cycle, the assertions check the following. Each edge rule sets its bit one edge after the input transition. A read with no concurrent event empties the register. An event that arrives with a read survives it. A masked bit in non-visible mode never goes from 0 to 1. The registered pin agrees with the latched unmasked bits. Several things only the bench's sweep can show: that falling edges of `line_open` and rising edges of `mframe_loss` set nothing, that every mask value in both visibility modes gives the right mix of latched, hidden and interrupting bits, and that a mid-run reset clears a populated register.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   // level inputs, packed order used by the top
   localparam int LVL_W     = 5;
   localparam int L_OPEN    = 0;
   localparam int L_SHORT   = 1;
   localparam int L_FLOSS   = 2;
   localparam int L_MFLOSS  = 3;
   localparam int L_SPACE   = 4;

   // status bit positions
   localparam int EV_W      = 5;
   localparam int B_LINECHG = 0;
   localparam int B_POOL    = 1;
   localparam int B_FAREC   = 2;
   localparam int B_FALOSS  = 3;
   localparam int B_MFAREC  = 4;

   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [EV_W-1:0]  ev_t;

   function automatic ev_t map_events(lvl_t rise, lvl_t fall, lvl_t chg);
      ev_t e;
      e            = '0;
      e[B_LINECHG] = rise[L_OPEN] | chg[L_SHORT];
      e[B_POOL]    = rise[L_SPACE];
      e[B_FAREC]   = fall[L_FLOSS];
      e[B_FALOSS]  = rise[L_FLOSS];
      e[B_MFAREC]  = fall[L_MFLOSS];
      return e;
   endfunction
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall,
   output logic [W-1:0] chg
);
   if (W < 1) begin : g_bad_w
      $error("evt_edge_det: W must be at least 1");
   end

   logic [W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise[i] =  lvl[i] & ~lvl_q[i];
      assign fall[i] = ~lvl[i] &  lvl_q[i];
      assign chg[i]  =  lvl[i] ^  lvl_q[i];
   end
endmodule

// File: rtl/evt_status_latch.sv
module evt_status_latch #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ev,
   input  logic [W-1:0] mask,
   input  logic         vis,
   input  logic         rd,
   output logic [W-1:0] status,
   output logic [W-1:0] status_nxt
);
   if (W < 1) begin : g_bad_w
      $error("evt_status_latch: W must be at least 1");
   end

   logic [W-1:0] accept;
   logic [W-1:0] kept;

   always_comb begin
      accept     = ev & (~mask | {W{vis}});
      kept       = rd ? '0 : status;
      status_nxt = kept | accept;
   end

   always_ff @(posedge clk) begin
      if (rst) status <= '0;
      else     status <= status_nxt;
   end
endmodule

// File: rtl/evt_irq_drive.sv
module evt_irq_drive #(
   parameter int W        = 5,
   parameter bit ACT_LOW  = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] status,
   input  logic [W-1:0] status_nxt,
   input  logic [W-1:0] mask,
   output logic         summary,
   output logic         irq_pin
);
   if (W < 1) begin : g_bad_w
      $error("evt_irq_drive: W must be at least 1");
   end

   logic pend_nxt;
   logic irq_q;

   assign summary  = |(status & ~mask);
   assign pend_nxt = |(status_nxt & ~mask);

   if (ACT_LOW) begin : g_low
      always_ff @(posedge clk) begin
         if (rst) irq_q <= 1'b1;
         else     irq_q <= ~pend_nxt;
      end
   end else begin : g_high
      always_ff @(posedge clk) begin
         if (rst) irq_q <= 1'b0;
         else     irq_q <= pend_nxt;
      end
   end

   assign irq_pin = irq_q;
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
   parameter int STATUS_W = evt_irq_pkg::EV_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                line_open,
   input  logic                line_short,
   input  logic                frame_loss,
   input  logic                mframe_loss,
   input  logic                pool_space,
   input  logic [STATUS_W-1:0] irq_mask,
   input  logic                vis_mode,
   input  logic                rd_stb,
   output logic [STATUS_W-1:0] status,
   output logic                summary,
   output logic                irq_n
);
   import evt_irq_pkg::*;

   if (STATUS_W != EV_W) begin : g_bad_w
      $error("evt_irq_status: STATUS_W must equal the event count");
   end

   lvl_t          lvl_vec;
   lvl_t          lvl_rise, lvl_fall, lvl_chg;
   logic [STATUS_W-1:0] ev_vec;
   logic [STATUS_W-1:0] status_nxt;

   always_comb begin
      lvl_vec           = '0;
      lvl_vec[L_OPEN]   = line_open;
      lvl_vec[L_SHORT]  = line_short;
      lvl_vec[L_FLOSS]  = frame_loss;
      lvl_vec[L_MFLOSS] = mframe_loss;
      lvl_vec[L_SPACE]  = pool_space;
   end

   evt_edge_det #(.W(LVL_W)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl_vec),
      .rise (lvl_rise),
      .fall (lvl_fall),
      .chg  (lvl_chg)
   );

   assign ev_vec = map_events(lvl_rise, lvl_fall, lvl_chg);

   evt_status_latch #(.W(STATUS_W)) u_latch (
      .clk        (clk),
      .rst        (rst),
      .ev         (ev_vec),
      .mask       (irq_mask),
      .vis        (vis_mode),
      .rd         (rd_stb),
      .status     (status),
      .status_nxt (status_nxt)
   );

   evt_irq_drive #(.W(STATUS_W), .ACT_LOW(1'b1)) u_drive (
      .clk        (clk),
      .rst        (rst),
      .status     (status),
      .status_nxt (status_nxt),
      .mask       (irq_mask),
      .summary    (summary),
      .irq_pin    (irq_n)
   );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
   parameter int W = 5
) (
   input logic         clk,
   input logic         rst,
   input logic         line_open,
   input logic         line_short,
   input logic         frame_loss,
   input logic         mframe_loss,
   input logic         pool_space,
   input logic [W-1:0] irq_mask,
   input logic         vis_mode,
   input logic         rd_stb,
   input logic [W-1:0] ev,
   input logic [W-1:0] status,
   input logic         summary,
   input logic         irq_n
);
   p_read_clears_r1: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && ev == '0) |=> (status == '0));

   p_line_change_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($rose(line_open) || !$stable(line_short)) && (vis_mode || !irq_mask[0]))
      |=> status[0]);

   p_pool_ready_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(pool_space) && (vis_mode || !irq_mask[1])) |=> status[1]);

   p_align_back_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(frame_loss) && (vis_mode || !irq_mask[2])) |=> status[2]);

   p_align_lost_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(frame_loss) && (vis_mode || !irq_mask[3])) |=> status[3]);

   p_mf_back_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(mframe_loss) && (vis_mode || !irq_mask[4])) |=> status[4]);

   p_hidden_no_irq_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(irq_mask) && ((status & ~irq_mask) == '0)) |-> (irq_n && !summary));

   p_masked_dropped_r8: assert property (@(posedge clk) disable iff (rst)
      !vis_mode |=> ((status & $past(irq_mask & ~status)) == '0));

   p_event_survives_r9: assert property (@(posedge clk) disable iff (rst)
      rd_stb |=> ((status & $past(ev & (~irq_mask | {W{vis_mode}})))
                  == $past(ev & (~irq_mask | {W{vis_mode}}))));

   p_pin_tracks_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq_n == ((status & ~$past(irq_mask)) == '0)));

   p_reset_state_r11: assert property (@(posedge clk)
      rst |=> (status == '0 && irq_n));
endmodule

bind evt_irq_status evt_irq_chk #(.W(STATUS_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .line_open   (line_open),
   .line_short  (line_short),
   .frame_loss  (frame_loss),
   .mframe_loss (mframe_loss),
   .pool_space  (pool_space),
   .irq_mask    (irq_mask),
   .vis_mode    (vis_mode),
   .rd_stb      (rd_stb),
   .ev          (ev_vec),
   .status      (status),
   .summary     (summary),
   .irq_n       (irq_n)
);

// File: tb/sim_evt_irq_status.sv
module sim_evt_irq_status;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       line_open = 0, line_short = 0, frame_loss = 0, mframe_loss = 0, pool_space = 0;
   logic [4:0] irq_mask = '0;
   logic       vis_mode = 0;
   logic       rd_stb = 0;
   logic [4:0] status;
   logic       summary;
   logic       irq_n;

   always #2 clk = ~clk;

   evt_irq_status u0 (
      .clk(clk), .rst(rst), .line_open(line_open), .line_short(line_short),
      .frame_loss(frame_loss), .mframe_loss(mframe_loss), .pool_space(pool_space),
      .irq_mask(irq_mask), .vis_mode(vis_mode), .rd_stb(rd_stb),
      .status(status), .summary(summary), .irq_n(irq_n)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;
   logic [4:0] m_prev = '0;   // bench's record of previous levels
   logic [4:0] m_stat = '0;   // bench's expected status

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // level order: 0 open, 1 short, 2 frame_loss, 3 mframe_loss, 4 pool_space
   task automatic step(input logic [4:0] lv, input logic [4:0] msk, input logic vis,
                       input logic rd, input string tag);
      logic [4:0] ev;
      logic [4:0] ok;
      @(negedge clk);
      line_open = lv[0]; line_short = lv[1]; frame_loss = lv[2];
      mframe_loss = lv[3]; pool_space = lv[4];
      irq_mask = msk; vis_mode = vis; rd_stb = rd;
      @(posedge clk);
      ev[0] = (lv[0] & ~m_prev[0]) | (lv[1] ^ m_prev[1]);
      ev[1] = lv[4] & ~m_prev[4];
      ev[2] = ~lv[2] & m_prev[2];
      ev[3] = lv[2] & ~m_prev[2];
      ev[4] = ~lv[3] & m_prev[3];
      ok     = vis ? 5'h1f : ~msk;
      m_stat = (rd ? 5'h00 : m_stat) | (ev & ok);
      m_prev = lv;
      #1;
      chk(tag, "status", {3'b0, status}, {3'b0, m_stat});
      chk(vis ? "R7" : "R10", "summary", {7'b0, summary}, {7'b0, |(m_stat & ~msk)});
      chk(vis ? "R7" : "R10", "irq_n", {7'b0, irq_n}, {7'b0, ~|(m_stat & ~msk)});
   endtask

   function automatic string tag_for(input int i, input bit rising);
      case (i)
         0, 1:    return "R2";
         2:       return rising ? "R5" : "R4";
         3:       return "R6";
         default: return "R3";
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      line_open = 0; line_short = 0; frame_loss = 0; mframe_loss = 0; pool_space = 0;
      rd_stb = 0;
      repeat (3) @(posedge clk);
      #1;
      m_prev = '0; m_stat = '0;
      chk("R11", "status after reset", {3'b0, status}, 8'h00);
      chk("R11", "summary after reset", {7'b0, summary}, 8'h00);
      chk("R11", "irq_n after reset", {7'b0, irq_n}, 8'h01);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [4:0] lv;
      string      t;
      do_reset();

      // sweep: both visibility modes, every mask, rise then fall of each level, then a read
      for (int vis = 0; vis < 2; vis++) begin
         for (int msk = 0; msk < 32; msk++) begin
            lv = '0;
            for (int i = 0; i < 5; i++) begin
               lv[i] = 1'b1;
               t = tag_for(i, 1'b1);
               if (vis == 0 && msk != 0) t = {t, "/R8"};
               step(lv, msk[4:0], vis[0], 1'b0, t);
               lv[i] = 1'b0;
               t = tag_for(i, 1'b0);
               if (vis == 0 && msk != 0) t = {t, "/R8"};
               step(lv, msk[4:0], vis[0], 1'b0, t);
            end
            step(lv, msk[4:0], vis[0], 1'b1, "R1");
         end
      end

      // event in the same cycle as a read survives it
      step(5'b00001, 5'h00, 1'b0, 1'b0, "R2");
      step(5'b00101, 5'h00, 1'b0, 1'b1, "R9");
      step(5'b00101, 5'h00, 1'b0, 1'b1, "R1");
      step(5'b10101, 5'h00, 1'b0, 1'b1, "R9");

      // masked hidden bit beside an unmasked one, visibility on
      step(5'b00000, 5'h1e, 1'b1, 1'b1, "R7");
      step(5'b00010, 5'h1e, 1'b1, 1'b1, "R7");
      step(5'b01010, 5'h1e, 1'b1, 1'b0, "R7");
      step(5'b00010, 5'h1e, 1'b1, 1'b0, "R7");

      // reset with bits populated
      do_reset();
      step(5'b00000, 5'h00, 1'b0, 1'b0, "R11");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule